// File: doc/BRIEF.md
# Verified Address Window Switcher

This block sits between a host register port and a backplane whose cores each occupy an equally sized register window. A single window base register selects which core is visible through the access path. For each host read or write, the block compares the target core with the core it last mapped. When the two match, it forwards the access at once. When they differ, it first reprograms the window base register and reads it back to confirm the switch. If the read-back does not match, it waits a fixed time and tries again, up to a bounded number of attempts.

A switch that keeps failing is abandoned. In that case a read returns all ones at the requested width, a write never reaches the core, and a one-cycle error pulse is raised. While the backplane is reported as powered down, every access fails in the same way and the window register is not touched. The host sees one request at a time. `busy_o` holds off new requests while a switch or an access is in progress, and every accepted request ends in exactly one `rsp_valid_o` pulse.

Top module: `window_switch`

## Requirements
- R1: On a request to a core that is not mapped, the block pulses `win_wr_o` with `win_wdata_o` = core × 2^OFF_W + ENUM_BASE. In the next cycle it pulses `win_rd_o` and samples `win_rdata_i` in that same cycle.
- R2: The read-back value is decoded as (value − ENUM_BASE) >> OFF_W over 32 bits, and the switch succeeds only if the result equals the requested core. On a mismatch that still has attempts left, the next `win_wr_o` comes exactly DELAY_CYC + 2 cycles after the previous one, where DELAY_CYC = CLK_FREQ_HZ / 100000 (10 µs).
- R3: A switch makes at most MAX_RETRIES + 2 window writes. If the read-back after the last of them still mismatches, the switch fails.
- R4: After reset no core is mapped. A request to the mapped core produces no window traffic. The mapped core changes only when a switch succeeds, so a failed switch leaves the previous mapping in place.
- R5: On a failed switch, a read responds with all ones at its width and a write causes no `acc_valid_o`. `err_o` pulses for one cycle, together with `rsp_valid_o`.
- R6: When `powered_i` is low at acceptance, the block responds in the next cycle with all ones at the request width. There is no window traffic, no `acc_valid_o` and no `err_o`.
- R7: Size code 0 selects 8 bits, 1 selects 16 bits and 2 selects 32 bits. Read data is the low bits of `acc_rdata_i` at that width, zero-extended to 32 bits.
- R8: A forwarded write presents the request's offset, size and write data on the access port for one `acc_valid_o` cycle, with `acc_write_o` high.
- R9: `busy_o` is high from the cycle after acceptance until the response cycle, and it is low while `rsp_valid_o` is high. Requests presented while busy are ignored.
- R10: While reset is held, `busy_o`, `rsp_valid_o`, `err_o`, `win_wr_o`, `win_rd_o` and `acc_valid_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| powered_i | input | 1 | Backplane power good |
| req_valid_i | input | 1 | Host request strobe, taken when not busy |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_core_i | input | CORE_W | Target core index |
| req_offset_i | input | OFF_W | Offset inside the core window |
| req_size_i | input | 2 | 0: 8 bit, 1: 16 bit, 2: 32 bit |
| req_wdata_i | input | 32 | Write data |
| busy_o | output | 1 | Request in progress |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 32 | Read data, all ones at the request width on failure |
| err_o | output | 1 | Switch-failure pulse |
| win_wr_o | output | 1 | Window base register write strobe |
| win_rd_o | output | 1 | Window base register read-back strobe |
| win_wdata_o | output | 32 | Window base value |
| win_rdata_i | input | 32 | Window base read-back value |
| acc_valid_o | output | 1 | Core access strobe |
| acc_write_o | output | 1 | Core access direction |
| acc_offset_o | output | OFF_W | Core access offset |
| acc_size_o | output | 2 | Core access width code |
| acc_wdata_o | output | 32 | Core write data |
| acc_rdata_i | input | 32 | Core read data, sampled in the `acc_valid_o` cycle |

## Verification
The hardest situations to reach are a window register that ignores writes for a chosen number of attempts and one that never accepts a write at all. From the host port alone neither can be forced. The bench's model of the window register therefore refuses a programmable number of writes, or all of them. This lets directed cases land exactly on the last successful attempt and on the first failing one, and lets the bench measure the spacing between retries. Random traffic then mixes cache hits, misses and occasional single retries. The bench tracks the expected mapped core throughout, including across a failed switch and a mid-run reset.

// File: rtl/window_switch_pkg.sv
package window_switch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_WAIT,
    ST_ACC
  } sw_state_e;

  localparam logic [1:0] SZ_B8  = 2'd0;
  localparam logic [1:0] SZ_B16 = 2'd1;

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_B8:   size_mask = 32'h0000_00FF;
      SZ_B16:  size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/win_codec.sv
module win_codec #(
  parameter int          CORE_W    = 4,
  parameter int          OFF_W     = 12,
  parameter logic [31:0] ENUM_BASE = 32'h1800_0000
) (
  input  logic [CORE_W-1:0] core_i,
  input  logic [31:0]       rb_i,
  output logic [31:0]       base_o,
  output logic              match_o
);
  logic [31:0] rel;

  assign base_o  = ENUM_BASE + (32'(core_i) << OFF_W);
  assign rel     = rb_i - ENUM_BASE;
  // full-width compare: stray high bits are a mismatch
  assign match_o = (rel >> OFF_W) == 32'(core_i);
endmodule

// File: rtl/retry_delay.sv
module retry_delay #(
  parameter int DELAY_CYC = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(DELAY_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= CW'(DELAY_CYC - 1);
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == '0);

  AST_DELAY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DELAY_CYC - 1)); // R2
endmodule

// File: rtl/rsp_gate.sv
module rsp_gate
  import window_switch_pkg::*;
(
  input  logic [1:0]  size_i,
  input  logic        fail_i,
  input  logic [31:0] data_i,
  output logic [31:0] data_o
);
  logic [31:0] mask;

  assign mask   = size_mask(size_i);
  assign data_o = fail_i ? mask : (data_i & mask);
endmodule

// File: rtl/window_switch.sv
module window_switch
  import window_switch_pkg::*;
#(
  parameter int          CORE_W      = 4,
  parameter int          OFF_W       = 12,
  parameter logic [31:0] ENUM_BASE   = 32'h1800_0000,
  parameter int          CLK_FREQ_HZ = 200_000_000,
  parameter int          MAX_RETRIES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              powered_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [CORE_W-1:0] req_core_i,
  input  logic [OFF_W-1:0]  req_offset_i,
  input  logic [1:0]        req_size_i,
  input  logic [31:0]       req_wdata_i,
  output logic              busy_o,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              err_o,
  output logic              win_wr_o,
  output logic              win_rd_o,
  output logic [31:0]       win_wdata_o,
  input  logic [31:0]       win_rdata_i,
  output logic              acc_valid_o,
  output logic              acc_write_o,
  output logic [OFF_W-1:0]  acc_offset_o,
  output logic [1:0]        acc_size_o,
  output logic [31:0]       acc_wdata_o,
  input  logic [31:0]       acc_rdata_i
);
  localparam int DELAY_RAW = CLK_FREQ_HZ / 100_000;
  localparam int DELAY_CYC = (DELAY_RAW < 1) ? 1 : DELAY_RAW;
  localparam int TRY_W     = $clog2(MAX_RETRIES + 2) + 1;

  sw_state_e         state_q;
  logic              wr_q;
  logic [CORE_W-1:0] core_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  logic [31:0]       wdata_q;
  logic [CORE_W-1:0] mapped_q;
  logic              mapped_ok_q;
  logic [TRY_W-1:0]  tries_q;
  logic              rsp_valid_q;
  logic [31:0]       rsp_rdata_q;
  logic              err_q;

  logic              rb_match;
  logic              out_of_tries;
  logic              tmr_load;
  logic              tmr_done;
  logic [1:0]        gate_size;
  logic              gate_fail;
  logic [31:0]       gate_data;

  win_codec #(
    .CORE_W   (CORE_W),
    .OFF_W    (OFF_W),
    .ENUM_BASE(ENUM_BASE)
  ) u_codec (
    .core_i (core_q),
    .rb_i   (win_rdata_i),
    .base_o (win_wdata_o),
    .match_o(rb_match)
  );

  assign out_of_tries = tries_q > TRY_W'(MAX_RETRIES);
  assign tmr_load     = (state_q == ST_RD) && !rb_match && !out_of_tries;

  retry_delay #(.DELAY_CYC(DELAY_CYC)) u_delay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .run_i (state_q == ST_WAIT),
    .done_o(tmr_done)
  );

  // idle path answers power-down from the live request fields
  assign gate_size = (state_q == ST_IDLE) ? req_size_i : size_q;
  assign gate_fail = (state_q != ST_ACC);

  rsp_gate u_gate (
    .size_i(gate_size),
    .fail_i(gate_fail),
    .data_i(acc_rdata_i),
    .data_o(gate_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      wr_q        <= 1'b0;
      core_q      <= '0;
      off_q       <= '0;
      size_q      <= '0;
      wdata_q     <= '0;
      mapped_q    <= '0;
      mapped_ok_q <= 1'b0;
      tries_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      err_q       <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      err_q       <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          wr_q    <= req_write_i;
          core_q  <= req_core_i;
          off_q   <= req_offset_i;
          size_q  <= req_size_i;
          wdata_q <= req_wdata_i;
          if (!powered_i) begin
            rsp_valid_q <= 1'b1;
            rsp_rdata_q <= gate_data;
          end else if (mapped_ok_q && mapped_q == req_core_i) begin
            state_q <= ST_ACC;
          end else begin
            tries_q <= '0;
            state_q <= ST_WR;
          end
        end
        ST_WR: state_q <= ST_RD;
        ST_RD: begin
          if (rb_match) begin
            mapped_q    <= core_q;
            mapped_ok_q <= 1'b1;
            state_q     <= ST_ACC;
          end else if (out_of_tries) begin
            rsp_valid_q <= 1'b1;
            rsp_rdata_q <= gate_data;
            err_q       <= 1'b1;
            state_q     <= ST_IDLE;
          end else begin
            tries_q <= tries_q + 1'b1;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (tmr_done) state_q <= ST_WR;
        ST_ACC: begin
          rsp_valid_q <= 1'b1;
          rsp_rdata_q <= gate_data;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_rdata_o  = rsp_rdata_q;
  assign err_o        = err_q;
  assign win_wr_o     = (state_q == ST_WR);
  assign win_rd_o     = (state_q == ST_RD);
  assign acc_valid_o  = (state_q == ST_ACC);
  assign acc_write_o  = wr_q;
  assign acc_offset_o = off_q;
  assign acc_size_o   = size_q;
  assign acc_wdata_o  = wdata_q;

  AST_RD_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_wr_o |=> win_rd_o); // R1
  AST_PORT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({win_wr_o, win_rd_o, acc_valid_o, rsp_valid_o})); // R9
  AST_TRY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tries_q <= TRY_W'(MAX_RETRIES + 1)); // R3
  AST_ACC_ON_MAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_o |-> (mapped_ok_q && mapped_q == core_q)); // R4
  AST_MAP_ONLY_ON_RB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RD) |=> $stable(mapped_q)); // R4
  AST_ERR_WITH_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rsp_valid_o && rsp_rdata_o == size_mask(size_q))); // R5
  AST_RSP_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !busy_o); // R9
endmodule

// File: tb/window_switch_test.sv
`timescale 1ns/1ps
module window_switch_test;
  localparam int          CORE_W = 4;
  localparam int          OFF_W  = 12;
  localparam logic [31:0] BASE   = 32'h1800_0000;
  localparam int          FREQ   = 200_000_000;
  localparam int          MAXR   = 2;
  localparam int          DELAY  = FREQ / 100_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic powered = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [CORE_W-1:0] req_core = '0;
  logic [OFF_W-1:0]  req_off = '0;
  logic [1:0]        req_size = '0;
  logic [31:0]       req_wdata = '0;
  logic busy, rsp_valid, err, win_wr, win_rd, acc_valid, acc_write;
  logic [31:0] rsp_rdata, win_wdata, win_rdata, acc_wdata, acc_rdata;
  logic [OFF_W-1:0] acc_off;
  logic [1:0] acc_size;

  always #2.5 clk = ~clk;

  window_switch #(
    .CORE_W(CORE_W), .OFF_W(OFF_W), .ENUM_BASE(BASE),
    .CLK_FREQ_HZ(FREQ), .MAX_RETRIES(MAXR)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .powered_i(powered),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_core_i(req_core),
    .req_offset_i(req_off), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .busy_o(busy), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .err_o(err),
    .win_wr_o(win_wr), .win_rd_o(win_rd), .win_wdata_o(win_wdata), .win_rdata_i(win_rdata),
    .acc_valid_o(acc_valid), .acc_write_o(acc_write), .acc_offset_o(acc_off),
    .acc_size_o(acc_size), .acc_wdata_o(acc_wdata), .acc_rdata_i(acc_rdata)
  );

  // window register model: refuses writes while stuck
  logic [31:0] win_reg;
  int  stuck_left = 0;
  bit  stuck_all  = 1'b0;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) win_reg <= '0;
    else if (win_wr && stuck_left == 0 && !stuck_all) win_reg <= win_wdata;
  assign win_rdata = win_reg;

  function automatic logic [31:0] core_data(input logic [31:0] base, input logic [OFF_W-1:0] off);
    return (base ^ 32'hC3A5_9E10) + {off, 4'h7, off[7:0], 8'h00};
  endfunction
  assign acc_rdata = core_data(win_reg, acc_off);

  function automatic logic [31:0] exp_base(input int core);
    return BASE + (32'(core) << OFF_W);
  endfunction
  function automatic logic [31:0] wmask(input int sz);
    return sz == 0 ? 32'hFF : sz == 1 ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  int n_chk = 0, n_bad = 0;
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int n_wr, n_acc, n_err, n_idle, gap;
  logic [31:0] rsp, wd_seen;
  logic a_wr; logic [OFF_W-1:0] a_off; logic [1:0] a_sz; logic [31:0] a_wd;

  task automatic xact(input bit wr, input int core, input int off, input int sz,
                      input logic [31:0] wd, input bit hold);
    int cyc, last;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_core = core[CORE_W-1:0];
    req_off = off[OFF_W-1:0]; req_size = sz[1:0]; req_wdata = wd;
    n_wr = 0; n_acc = 0; n_err = 0; n_idle = 0; gap = 0; cyc = 0; last = -1;
    rsp = 'x; a_wr = 1'b0;
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    forever begin
      cyc++;
      if (win_wr) begin
        if (last >= 0) gap = cyc - last;
        last = cyc; n_wr++; wd_seen = win_wdata;
      end
      if (win_rd && stuck_left > 0) stuck_left--;
      if (acc_valid) begin
        n_acc++; a_wr = acc_write; a_off = acc_off; a_sz = acc_size; a_wd = acc_wdata;
      end
      if (err) n_err++;
      if (rsp_valid) begin rsp = rsp_rdata; break; end
      if (!busy) n_idle++;
      if (cyc > 20000) break;
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit map_ok;
    int map_core;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check({busy, rsp_valid, err, win_wr, win_rd, acc_valid} == 6'b0, "R10 reset outputs",
          {26'b0, busy, rsp_valid, err, win_wr, win_rd, acc_valid}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    // first access switches
    xact(1'b0, 3, 'h123, 2, '0, 1'b0);
    check(n_wr == 1, "R1 miss writes once", n_wr, 1);
    check(wd_seen == exp_base(3), "R1 window base", wd_seen, exp_base(3));
    check(rsp == core_data(exp_base(3), 'h123), "R7 read32", rsp, core_data(exp_base(3), 'h123));
    // hit
    xact(1'b0, 3, 'h0F1, 0, '0, 1'b0);
    check(n_wr == 0, "R4 hit no switch", n_wr, 0);
    check(rsp == (core_data(exp_base(3), 'h0F1) & 32'hFF), "R7 read8", rsp,
          core_data(exp_base(3), 'h0F1) & 32'hFF);
    xact(1'b0, 3, 'h0F2, 1, '0, 1'b0);
    check(rsp == (core_data(exp_base(3), 'h0F2) & 32'hFFFF), "R7 read16", rsp,
          core_data(exp_base(3), 'h0F2) & 32'hFFFF);
    // write forwarding
    xact(1'b1, 3, 'hABC, 1, 32'hDEAD_BEEF, 1'b0);
    check(n_acc == 1 && a_wr, "R8 write strobe", n_acc, 1);
    check({a_off, a_sz} == {12'hABC, 2'd1}, "R8 offset/size", {a_off, a_sz}, {12'hABC, 2'd1});
    check(a_wd == 32'hDEAD_BEEF, "R8 wdata", a_wd, 32'hDEAD_BEEF);
    // one retry
    stuck_left = 1;
    xact(1'b0, 5, 'h010, 2, '0, 1'b0);
    check(n_wr == 2, "R2 one retry", n_wr, 2);
    check(gap == DELAY + 2, "R2 retry spacing", gap, DELAY + 2);
    check(rsp == core_data(exp_base(5), 'h010) && n_err == 0, "R2 retry data", rsp,
          core_data(exp_base(5), 'h010));
    // last attempt succeeds
    stuck_left = MAXR + 1;
    xact(1'b0, 6, 'h020, 2, '0, 1'b0);
    check(n_wr == MAXR + 2 && n_err == 0, "R3 last attempt ok", n_wr, MAXR + 2);
    check(rsp == core_data(exp_base(6), 'h020), "R3 last attempt data", rsp, core_data(exp_base(6), 'h020));
    // permanent failure
    stuck_all = 1'b1;
    xact(1'b0, 9, 'h030, 1, '0, 1'b0);
    check(n_wr == MAXR + 2, "R3 attempts before fail", n_wr, MAXR + 2);
    check(rsp == 32'h0000_FFFF, "R5 fail read16 ones", rsp, 32'h0000_FFFF);
    check(n_err == 1 && n_acc == 0, "R5 err pulse no access", n_err, 1);
    xact(1'b1, 9, 'h030, 2, 32'h1234_5678, 1'b0);
    check(n_acc == 0 && n_err == 1, "R5 fail write dropped", n_acc, 0);
    stuck_all = 1'b0;
    xact(1'b0, 6, 'h040, 0, '0, 1'b0);
    check(n_wr == 0, "R4 cache kept after fail", n_wr, 0);
    check(rsp == (core_data(exp_base(6), 'h040) & 32'hFF), "R4 cached data", rsp,
          core_data(exp_base(6), 'h040) & 32'hFF);
    xact(1'b0, 9, 'h050, 2, '0, 1'b0);
    check(n_wr == 1, "R4 failed core not cached", n_wr, 1);
    // power down
    powered = 1'b0;
    xact(1'b0, 2, 'h060, 2, '0, 1'b0);
    check(rsp == 32'hFFFF_FFFF, "R6 power-down ones", rsp, 32'hFFFF_FFFF);
    check(n_wr == 0 && n_acc == 0 && n_err == 0, "R6 no traffic", n_wr + n_acc + n_err, 0);
    xact(1'b1, 9, 'h060, 0, 32'h55, 1'b0);
    check(n_acc == 0 && rsp == 32'hFF, "R6 write dropped", rsp, 32'hFF);
    powered = 1'b1;
    // request held while busy
    xact(1'b0, 4, 'h070, 2, '0, 1'b1);
    check(n_wr == 1 && n_acc == 1, "R9 held request once", n_acc, 1);
    check(n_idle == 0, "R9 busy until rsp", n_idle, 0);
    @(negedge clk);
    check(!busy && !acc_valid, "R9 no second accept", {31'b0, busy}, 32'd0);
    // reset clears the cache
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check(!busy && !rsp_valid, "R10 reset mid-run", {31'b0, busy}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    xact(1'b0, 4, 'h080, 2, '0, 1'b0);
    check(n_wr == 1, "R4 cache cleared by reset", n_wr, 1);
    map_ok = 1'b1; map_core = 4;

    for (int i = 0; i < 150; i++) begin
      int core, sz, off, exp_wr;
      bit wr, hit;
      logic [31:0] wd;
      core = $urandom_range(0, 15); sz = $urandom_range(0, 2);
      off = $urandom_range(0, 4095); wr = 1'($urandom_range(0, 1)); wd = $urandom;
      hit = map_ok && core == map_core;
      stuck_left = (!hit && $urandom_range(0, 7) == 0) ? 1 : 0;
      exp_wr = hit ? 0 : 1 + stuck_left;
      xact(wr, core, off, sz, wd, 1'b0);
      check(n_wr == exp_wr, "R4 random switch count", n_wr, exp_wr);
      if (wr)
        check(n_acc == 1 && a_wd == wd && a_off == off[OFF_W-1:0], "R8 random write", a_wd, wd);
      else
        check(rsp == (core_data(exp_base(core), off[OFF_W-1:0]) & wmask(sz)), "R7 random read",
              rsp, core_data(exp_base(core), off[OFF_W-1:0]) & wmask(sz));
      map_ok = 1'b1; map_core = core;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule